// File: doc/BRIEF.md
# Switch Global Reset and Ready Sequencer

This block holds the global control and status words of a small packet switch. A host writes a 16-bit control word and reads back either that word or a status word. Setting the reset bit of the control word fires a fixed-length reset pulse into every internal unit, such as the address table and the VLAN table. The block then withholds its ready indication until each unit reports through its own done input that it has finished initializing and can take frames. The reset bit clears by itself once the pulse has been issued.

A second control bit runs a background PHY polling engine, which is modelled here only by a run/acknowledge handshake. The status word carries a two-bit engine state: off, detecting, running or stopping. A host that enables the engine waits for "running". A host that disables it waits for "off". The engine is held stopped for the whole reset window. When a reset is written together with the enable bit, the engine therefore stops and, after the units are ready, goes through PHY detection again from the start. Control bits written while the reset window is open are stored and read back at once, but they reach the outputs only when ready returns.

Top module: `sw_global_seq`

## Requirements
- R1: After power-on reset the ready flag reads 0 until every unit_done input is high. From then on the status word reads 16'h0800, the control word reads 0, and unit_rst, poll_run and cfg_out are all 0.
- R2: A control write (host_sel=0) with bit 15 set while ready drives unit_rst high for exactly RST_CYCLES cycles, starting the cycle after the write.
- R3: Control bit 15 reads 1 while the reset pulse is active and reads 0 once the pulse ends. No host write is needed to clear it.
- R4: Status bit 11 (ready) is 0 from the reset write onward. It rises one cycle after the first cycle, following the pulse, in which all unit_done inputs are high.
- R5: unit_done values seen during the reset pulse are ignored. If the units hold done high throughout, ready rises one cycle after the pulse ends.
- R6: Status bits [13:12] hold the engine state: 00 off, 01 detecting, 10 running, 11 stopping. Setting control bit 14 moves the field from 00 to 01, and then to 10 once poll_ack is high.
- R7: Clearing control bit 14 while the engine is running moves the field to 11, and then to 00 once poll_ack is low.
- R8: A reset write with bit 14 set, made while the engine is running, takes the field through 11, 00, 01 and back to 10.
- R9: Control bits [14:0] written while ready is 0 read back at once on the control word. cfg_out and poll_run keep their old values until ready returns, and take the new values within three cycles after that.
- R10: poll_run is 0 whenever unit_rst is high.
- R11: Writes with host_sel=1 change nothing. Status bits other than 11 and [13:12] read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 1 | Word select: 0 control, 1 status |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Selected word, combinational |
| unit_done | input | NUM_UNITS | Per-unit initialization done |
| unit_rst | output | 1 | Reset pulse to internal units |
| poll_run | output | 1 | Run request to the polling engine |
| poll_ack | input | 1 | Engine reports detection finished and polling |
| cfg_out | output | 14 | Applied general control bits [13:0] |

## Verification
The bench builds the block with NUM_UNITS=3 and RST_CYCLES=4. The units become ready after 3, 5 and 7 cycles, and the engine answers after 3 cycles. A short pulse and short unit latencies keep every reset window to about a dozen cycles. Within that window the bench can measure the exact pulse width and the exact delay to ready, and it can place a second control write inside the pulse. The engine delay is shorter than the reset window, so the full restart sequence through stopping, off and detecting can be observed.

// File: rtl/swg_pkg.sv
package swg_pkg;
    localparam int REG_W     = 16;
    localparam int CTL_RST   = 15;
    localparam int CTL_POLL  = 14;
    localparam int CFG_W     = 14;
    localparam int HELD_W    = REG_W - 1;
    localparam int STS_RDY   = 11;
    localparam int STS_PS_LO = 12;

    typedef enum logic [1:0] {
        SEQ_PULSE = 2'd0,
        SEQ_WAIT  = 2'd1,
        SEQ_IDLE  = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        PE_OFF    = 2'b00,
        PE_DETECT = 2'b01,
        PE_RUN    = 2'b10,
        PE_STOP   = 2'b11
    } pe_state_e;
endpackage

// File: rtl/swg_rst_seq.sv
module swg_rst_seq
    import swg_pkg::*;
#(
    parameter int NUM_UNITS  = 4,
    parameter int RST_CYCLES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic [NUM_UNITS-1:0] unit_done,
    output logic                 unit_rst,
    output logic                 ready
);
    localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_CYCLES - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
    } seq_regs_t;

    seq_regs_t s_d, s_q;
    logic      all_done;

    assign all_done = &unit_done;

    always_comb begin
        s_d = s_q;
        case (s_q.state)
            SEQ_PULSE: begin
                if (s_q.cnt == CNT_LAST) begin
                    s_d.state = SEQ_WAIT;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            SEQ_WAIT: begin
                if (all_done) s_d.state = SEQ_IDLE;
            end
            SEQ_IDLE: begin
                if (req) begin
                    s_d.state = SEQ_PULSE;
                    s_d.cnt   = '0;
                end
            end
            default: s_d.state = SEQ_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state <= SEQ_WAIT;
            s_q.cnt   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign unit_rst = (s_q.state == SEQ_PULSE);
    assign ready    = (s_q.state == SEQ_IDLE);

    // Independent length counter for the pulse window check
    logic [CNT_W:0] hi_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hi_len_q <= '0;
        else if (unit_rst) hi_len_q <= hi_len_q + 1'b1;
        else               hi_len_q <= '0;
    end

    assert_pulse_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(unit_rst) |-> (hi_len_q == (CNT_W+1)'(RST_CYCLES)));

    assert_req_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req) |=> unit_rst);

    assert_ready_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(all_done));
endmodule

// File: rtl/swg_poll_track.sv
module swg_poll_track
    import swg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    input  logic      ack,
    output pe_state_e state
);
    pe_state_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q)
            PE_OFF:    if (run) st_d = PE_DETECT;
            PE_DETECT: begin
                if (!run)     st_d = PE_STOP;
                else if (ack) st_d = PE_RUN;
            end
            PE_RUN:    if (!run) st_d = PE_STOP;
            PE_STOP:   if (!ack) st_d = PE_OFF;
            default:   st_d = PE_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PE_OFF;
        else        st_q <= st_d;
    end

    assign state = st_q;

    assert_run_needs_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PE_RUN && $past(st_q) != PE_RUN) |-> $past(ack));

    assert_off_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PE_OFF) |=> (st_q == PE_OFF || st_q == PE_DETECT));

    assert_off_needs_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PE_OFF && $past(st_q) != PE_OFF) |-> $past(!ack));
endmodule

// File: rtl/swg_cfg_regs.sv
module swg_cfg_regs #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         apply,
    output logic [W-1:0] pend,
    output logic [W-1:0] act
);
    typedef struct packed {
        logic [W-1:0] pend;
        logic [W-1:0] act;
    } cfg_regs_t;

    cfg_regs_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (wr)    c_d.pend = wdata;
        if (apply) c_d.act  = c_q.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign pend = c_q.pend;
    assign act  = c_q.act;
endmodule

// File: rtl/sw_global_seq.sv
module sw_global_seq
    import swg_pkg::*;
#(
    parameter int NUM_UNITS  = 4,
    parameter int RST_CYCLES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_wr,
    input  logic                 host_sel,
    input  logic [REG_W-1:0]     host_wdata,
    output logic [REG_W-1:0]     host_rdata,
    input  logic [NUM_UNITS-1:0] unit_done,
    output logic                 unit_rst,
    output logic                 poll_run,
    input  logic                 poll_ack,
    output logic [CFG_W-1:0]     cfg_out
);
    logic              ctl_wr;
    logic              rst_req;
    logic              ready;
    logic [HELD_W-1:0] pend;
    logic [HELD_W-1:0] act;
    pe_state_e         pe_st;

    assign ctl_wr  = host_wr && !host_sel;
    assign rst_req = ctl_wr && host_wdata[CTL_RST];

    swg_cfg_regs #(.W(HELD_W)) cfg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ctl_wr),
        .wdata (host_wdata[HELD_W-1:0]),
        .apply (ready),
        .pend  (pend),
        .act   (act)
    );

    swg_rst_seq #(.NUM_UNITS(NUM_UNITS), .RST_CYCLES(RST_CYCLES)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (rst_req),
        .unit_done (unit_done),
        .unit_rst  (unit_rst),
        .ready     (ready)
    );

    assign poll_run = act[CTL_POLL] && ready;
    assign cfg_out  = act[CFG_W-1:0];

    swg_poll_track trk_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (poll_run),
        .ack   (poll_ack),
        .state (pe_st)
    );

    always_comb begin
        host_rdata = '0;
        if (!host_sel) begin
            host_rdata[HELD_W-1:0] = pend;
            host_rdata[CTL_RST]    = unit_rst;
        end else begin
            host_rdata[STS_RDY]         = ready;
            host_rdata[STS_PS_LO +: 2]  = pe_st;
        end
    end

    assert_cfg_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(cfg_out));

    assert_run_off_in_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        unit_rst |-> !poll_run);
endmodule

// File: tb/sw_global_seq_tb_top.sv
module sw_global_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NU         = 3;
    localparam int RC         = 4;
    localparam int LMAX       = 3 + 2 * (NU - 1);
    localparam int ENG_LAT    = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0;
    logic          host_sel = 1'b0;
    logic [15:0]   host_wdata = '0;
    logic [15:0]   host_rdata;
    logic [NU-1:0] unit_done;
    logic          unit_rst;
    logic          poll_run;
    logic          poll_ack;
    logic [13:0]   cfg_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    sw_global_seq #(.NUM_UNITS(NU), .RST_CYCLES(RC)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .unit_done(unit_done),
        .unit_rst(unit_rst), .poll_run(poll_run), .poll_ack(poll_ack), .cfg_out(cfg_out)
    );

    // Unit models: done drops during the pulse, returns after 3,5,7 cycles
    logic [5:0] ucnt;
    logic       force_hi = 1'b0;
    always @(posedge clk) begin
        if (!rst_n || unit_rst) ucnt <= '0;
        else if (ucnt != 6'd63) ucnt <= ucnt + 1'b1;
    end
    always_comb begin
        for (int i = 0; i < NU; i++) unit_done[i] = force_hi || (int'(ucnt) >= 3 + 2 * i);
    end

    // Polling engine model: ack follows run after ENG_LAT cycles
    logic [3:0] ecnt;
    always @(posedge clk) begin
        if (!rst_n) begin
            poll_ack <= 1'b0;
            ecnt     <= '0;
        end else if (poll_run != poll_ack) begin
            if (int'(ecnt) == ENG_LAT - 1) begin
                poll_ack <= poll_run;
                ecnt     <= '0;
            end else begin
                ecnt <= ecnt + 1'b1;
            end
        end else begin
            ecnt <= '0;
        end
    end

    int checks = 0;
    int fails  = 0;

    task automatic note(input bit ok, input string req, input string what,
                        input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Scoreboard: sel 0 control word, 1 status word, 2 {unit_rst, poll_run, cfg_out}
    typedef struct {
        int          sel;
        logic [15:0] mask;
        logic [15:0] exp;
        string       req;
    } item_t;
    item_t q[$];
    logic  probe = 1'b0;

    always @(negedge clk) begin
        if (probe && q.size() > 0) begin
            item_t it;
            logic [15:0] obs;
            it  = q.pop_front();
            obs = (it.sel == 2) ? {unit_rst, poll_run, cfg_out} : host_rdata;
            note(((obs ^ it.exp) & it.mask) == 16'h0, it.req, "probe",
                 int'(obs & it.mask), int'(it.exp & it.mask));
        end
    end

    task automatic expect_at(input int sel, input logic [15:0] mask,
                             input logic [15:0] exp, input string req);
        item_t it;
        @(posedge clk); #1;
        host_sel = (sel == 1);
        it.sel = sel; it.mask = mask; it.exp = exp; it.req = req;
        q.push_back(it);
        probe = 1'b1;
        @(negedge clk); #1;
        probe = 1'b0;
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        @(posedge clk); #1;
        host_sel = sel; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic next_state(input logic [1:0] exp, input string req);
        logic [1:0] cur;
        int n;
        host_sel = 1'b1; #1;
        cur = host_rdata[13:12];
        n = 0;
        while (host_rdata[13:12] == cur && n < 300) begin
            @(negedge clk); n++;
        end
        note(host_rdata[13:12] == exp, req, "engine state", int'(host_rdata[13:12]), int'(exp));
    endtask

    task automatic wait_ready();
        int n;
        host_sel = 1'b1; #1;
        n = 0;
        while (!host_rdata[11] && n < 500) begin
            @(negedge clk); n++;
        end
    endtask

    // Measures pulse width and delay to ready after a reset write
    task automatic reset_run(input int exp_k, input string req_k);
        int hi, k;
        bit bad3, bad4;
        wr(1'b0, 16'h8000);
        host_sel = 1'b0;
        @(negedge clk);
        hi = 0; bad3 = 0;
        while (unit_rst === 1'b1 && hi < 100) begin
            if (host_rdata[15] !== 1'b1) bad3 = 1;
            hi++;
            @(negedge clk);
        end
        note(hi == RC, "R2", "pulse width", hi, RC);
        note(!bad3, "R3", "bit15 during pulse", 0, 1);
        note(host_rdata[15] == 1'b0, "R3", "bit15 after pulse", int'(host_rdata[15]), 0);
        host_sel = 1'b1; #1;
        k = 0; bad4 = 0;
        while (!host_rdata[11] && k < 100) begin
            @(negedge clk); k++;
        end
        note(k == exp_k, req_k, "cycles from pulse end to ready", k, exp_k);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: power-on state
        expect_at(1, 16'h0800, 16'h0000, "R1");
        wait_ready();
        expect_at(1, 16'hFFFF, 16'h0800, "R1");
        expect_at(0, 16'hFFFF, 16'h0000, "R1");
        expect_at(2, 16'hFFFF, 16'h0000, "R1");

        // R11: status-select writes are ignored
        wr(1'b1, 16'hFFFF);
        expect_at(0, 16'hFFFF, 16'h0000, "R11");
        expect_at(1, 16'hFFFF, 16'h0800, "R11");
        expect_at(2, 16'hFFFF, 16'h0000, "R11");

        // R6: enable the engine
        wr(1'b0, 16'h4000);
        next_state(2'b01, "R6");
        next_state(2'b10, "R6");
        expect_at(1, 16'hFFFF, 16'h2800, "R6");

        // R7: disable the engine
        wr(1'b0, 16'h0000);
        next_state(2'b11, "R7");
        next_state(2'b00, "R7");
        expect_at(2, 16'h4000, 16'h0000, "R7");

        // R8: restart with reset plus enable
        wr(1'b0, 16'h4000);
        next_state(2'b01, "R6");
        next_state(2'b10, "R6");
        wr(1'b0, 16'hC000);
        next_state(2'b11, "R8");
        next_state(2'b00, "R8");
        next_state(2'b01, "R8");
        next_state(2'b10, "R8");
        expect_at(0, 16'hFFFF, 16'h4000, "R3");

        // R2, R3, R4: pulse width and ready delay
        reset_run(LMAX + 1, "R4");

        // R5: done held high through the pulse
        force_hi = 1'b1;
        reset_run(1, "R5");
        force_hi = 1'b0;

        // R9, R10: writes inside the reset window
        wr(1'b0, 16'h0123);
        repeat (3) @(posedge clk);
        expect_at(2, 16'h7FFF, 16'h0123, "R9");
        wr(1'b0, 16'h8123);
        wr(1'b0, 16'h4ABC);
        expect_at(2, 16'hFFFF, 16'h8123, "R10");
        expect_at(0, 16'h7FFF, 16'h4ABC, "R9");
        wait_ready();
        repeat (3) @(posedge clk);
        expect_at(2, 16'h7FFF, 16'h4ABC, "R9");
        expect_at(2, 16'h4000, 16'h4000, "R10");

        repeat (2) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule